// File: doc/BRIEF.md
# DMA Stream Transfer Sequencer

This block is the control engine of a single DMA stream. It counts data items, produces the source and destination addresses for each item, reloads itself for circular operation, alternates between two memory buffers in double-buffer (ping-pong) operation, and records five event flags. These flags are enabled individually and combined into one interrupt line. The block does not move any data and does not arbitrate between streams. A data path outside the block answers each offered item with an acknowledge, and the sequencer advances on that acknowledge.

The end of a transfer can come from two sources. In the first, the sequencer counts down a programmed number of items. In the second, the peripheral controls the flow and marks the last item with an end signal, so the count is not used. Transfers can run peripheral-to-memory, memory-to-peripheral or memory-to-memory. A memory-to-memory transfer waits for a software trigger and does not use the peripheral request.

Top module: `dma_stream_seq`

## Requirements
- R1: A rising edge of `cfg_en` while idle starts a transfer, provided that `cfg_count` is non-zero or peripheral flow control is selected. On start, `remaining` is loaded with `cfg_count`, both addresses return to their start values (memory side from `cfg_m0addr`), `buf_sel` is cleared and `active` is set. A start request with a zero count under item-count flow control is ignored, and the stream stays idle.
- R2: `xfer_valid` is high while the stream is active and a request is present. One item completes in a cycle where `xfer_valid` and `xfer_ack` are both high. If no acknowledge arrives, nothing advances.
- R3: The direction code `cfg_dir` takes these values: 0 is peripheral-to-memory, 1 is memory-to-peripheral and 2 is memory-to-memory. For code 1, `src_addr` is the memory address and `dst_addr` is the peripheral address. For codes 0 and 2 the two are swapped. After each item, an address whose increment enable is set advances by its size in bytes: size code 0 gives 1 byte, 1 gives 2 bytes and 2 gives 4 bytes. An address whose increment enable is clear stays where it is.
- R4: Under item-count flow control, each item decrements `remaining`. In normal mode, the item that brings it to zero sets the transfer-complete flag (bit 1) and clears `active`.
- R5: In circular mode, the item that brings the count to zero reloads the count and both start addresses. It also sets transfer-complete, and the stream stays active.
- R6: In double-buffer mode, circular operation is forced on. Each completed pass toggles `buf_sel`, and the memory address reloads from `cfg_m1addr` when the new `buf_sel` is 1, or from `cfg_m0addr` when it is 0.
- R7: The half-transfer flag (bit 0) sets on the item after which `remaining` equals the programmed count divided by two, rounded down.
- R8: Under peripheral flow control, `remaining` does not change. The transfer ends when `periph_end` is high while active, which sets transfer-complete and clears `active`. The half-transfer flag never sets in this mode.
- R9: In memory-to-memory mode, `item_req` is ignored. Items are offered only from the cycle after an `sw_trig` pulse seen while active.
- R10: `err_xfer` while active sets the transfer-error flag (bit 2) and stops the stream. `err_fifo` (bit 3) and `err_direct` (bit 4) set their flags while active and do not stop the stream.
- R11: Flags stay set until a 1 is written to the matching bit of `flag_clr`. An event and a clear on the same flag in the same cycle leave the flag set.
- R12: `irq` is the OR of all flags ANDed with their bits in `flag_ie`.
- R13: Dropping `cfg_en` while active stops the stream at the next clock. This holds `remaining` and does not set transfer-complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Stream enable; a rising edge starts a transfer |
| cfg_dir | input | 2 | Direction: 0 periph-to-mem, 1 mem-to-periph, 2 mem-to-mem |
| cfg_pfc | input | 1 | Peripheral flow control select |
| cfg_circ | input | 1 | Circular mode |
| cfg_dbuf | input | 1 | Double-buffer mode |
| cfg_pinc | input | 1 | Peripheral-side address increment enable |
| cfg_minc | input | 1 | Memory-side address increment enable |
| cfg_psize | input | 2 | Peripheral item size code (0:1, 1:2, 2:4 bytes) |
| cfg_msize | input | 2 | Memory item size code (0:1, 1:2, 2:4 bytes) |
| cfg_count | input | 16 | Programmed item count |
| cfg_paddr | input | 32 | Peripheral-side start address |
| cfg_m0addr | input | 32 | Memory buffer 0 start address |
| cfg_m1addr | input | 32 | Memory buffer 1 start address |
| flag_ie | input | 5 | Per-flag interrupt enable |
| flag_clr | input | 5 | Write-one-to-clear flag strobes |
| sw_trig | input | 1 | Software trigger for memory-to-memory |
| item_req | input | 1 | Peripheral item request |
| xfer_ack | input | 1 | Data path has completed the offered item |
| periph_end | input | 1 | Peripheral end-of-transfer |
| err_xfer | input | 1 | Bus transfer error |
| err_fifo | input | 1 | FIFO error event |
| err_direct | input | 1 | Direct-mode error event |
| xfer_valid | output | 1 | Item offered to the data path |
| src_addr | output | 32 | Source address of the current item |
| dst_addr | output | 32 | Destination address of the current item |
| remaining | output | 16 | Items left in the current pass |
| active | output | 1 | Stream running |
| buf_sel | output | 1 | Memory buffer currently targeted |
| flags | output | 5 | Sticky flags: 0 half, 1 complete, 2 xfer error, 3 FIFO error, 4 direct error |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is the wrap item in double-buffer mode. On that one beat, the count reload, the buffer toggle, the memory reload from the other buffer register and the half and complete flags must all agree. The sweep reaches it by holding request and acknowledge high through just over two passes. It does this for every count from 1 to 5, which includes count 1, where half-transfer and transfer-complete fall on the same item. Every direction, size pair, increment setting and mode is covered. Memory-to-memory runs are first opened with a trigger pulse.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [1:0] {
        DIR_P2M = 2'd0,
        DIR_M2P = 2'd1,
        DIR_M2M = 2'd2
    } dir_e;

    localparam int FLAG_HT    = 0;
    localparam int FLAG_TC    = 1;
    localparam int FLAG_TE    = 2;
    localparam int FLAG_FE    = 3;
    localparam int FLAG_DME   = 4;
    localparam int NUM_FLAGS  = 5;

    // Item size code to byte step; code 3 is treated as a word
    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_seq_addr.sv
module dma_seq_addr
    import dma_seq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step_en,
    input  logic          inc_en,
    input  logic [1:0]    size_code,
    output logic [AW-1:0] addr
);

    typedef struct packed {
        logic [AW-1:0] addr;
    } addr_st_t;

    addr_st_t st_d, st_q;
    logic [AW-1:0] step;

    always_comb begin
        step = AW'(size_bytes(size_code));
        st_d = st_q;
        if (load) begin
            st_d.addr = load_val;
        end else if (step_en && inc_en) begin
            st_d.addr = st_q.addr + step;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr = st_q.addr;

    AST_ADDR_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load && !inc_en) |=> $stable(addr)); // R3
    AST_ADDR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (addr == $past(load_val))); // R5

endmodule

// File: rtl/dma_seq_flags.sv
module dma_seq_flags #(
    parameter int NF = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set,
    input  logic [NF-1:0] clr,
    input  logic [NF-1:0] ie,
    output logic [NF-1:0] flags,
    output logic          irq
);

    typedef struct packed {
        logic [NF-1:0] f;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        // an event in the same cycle as its clear keeps the flag set
        st_d.f = (st_q.f & ~clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.f;
    assign irq   = |(st_q.f & ie);

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.f & ~clr) != '0) |=> ((st_q.f & $past(st_q.f & ~clr)) == $past(st_q.f & ~clr))); // R11
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> ((st_q.f & $past(set)) == $past(set))); // R11

endmodule

// File: rtl/dma_stream_seq.sv
module dma_stream_seq
    import dma_seq_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_en,
    input  logic [1:0]           cfg_dir,
    input  logic                 cfg_pfc,
    input  logic                 cfg_circ,
    input  logic                 cfg_dbuf,
    input  logic                 cfg_pinc,
    input  logic                 cfg_minc,
    input  logic [1:0]           cfg_psize,
    input  logic [1:0]           cfg_msize,
    input  logic [CW-1:0]        cfg_count,
    input  logic [AW-1:0]        cfg_paddr,
    input  logic [AW-1:0]        cfg_m0addr,
    input  logic [AW-1:0]        cfg_m1addr,
    input  logic [NUM_FLAGS-1:0] flag_ie,
    input  logic [NUM_FLAGS-1:0] flag_clr,
    input  logic                 sw_trig,
    input  logic                 item_req,
    input  logic                 xfer_ack,
    input  logic                 periph_end,
    input  logic                 err_xfer,
    input  logic                 err_fifo,
    input  logic                 err_direct,
    output logic                 xfer_valid,
    output logic [AW-1:0]        src_addr,
    output logic [AW-1:0]        dst_addr,
    output logic [CW-1:0]        remaining,
    output logic                 active,
    output logic                 buf_sel,
    output logic [NUM_FLAGS-1:0] flags,
    output logic                 irq
);

    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    typedef struct packed {
        logic          active;
        logic          en_prev;
        logic          trig;
        logic          buf_sel;
        logic          pfc;
        logic          wrap_mode;
        logic          dbuf;
        dir_e          dir;
        logic [CW-1:0] rem;
        logic [CW-1:0] len;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                 start, beat, last, wrap, half_hit, end_hit, stop;
    logic [CW-1:0]        rem_dec;
    logic [AW-1:0]        per_addr, mem_addr, mem_reload;
    logic [NUM_FLAGS-1:0] ev;

    always_comb begin
        start      = cfg_en && !ctl_q.en_prev && !ctl_q.active && (cfg_pfc || cfg_count != '0);
        xfer_valid = ctl_q.active && ((ctl_q.dir == DIR_M2M) ? ctl_q.trig : item_req);
        beat       = xfer_valid && xfer_ack;
        rem_dec    = ctl_q.rem - CNT_ONE;
        last       = beat && !ctl_q.pfc && (ctl_q.rem == CNT_ONE);
        wrap       = last && ctl_q.wrap_mode;
        half_hit   = beat && !ctl_q.pfc && (rem_dec == (ctl_q.len >> 1));
        end_hit    = ctl_q.active && ctl_q.pfc && periph_end;

        ev           = '0;
        ev[FLAG_HT]  = half_hit;
        ev[FLAG_TC]  = last || end_hit;
        ev[FLAG_TE]  = ctl_q.active && err_xfer;
        ev[FLAG_FE]  = ctl_q.active && err_fifo;
        ev[FLAG_DME] = ctl_q.active && err_direct;

        stop = !cfg_en || ev[FLAG_TE] || (last && !wrap) || end_hit;

        // next memory start: buffer 0 on start, otherwise the buffer being switched to
        mem_reload = (!start && ctl_q.dbuf && !ctl_q.buf_sel) ? cfg_m1addr : cfg_m0addr;

        ctl_d         = ctl_q;
        ctl_d.en_prev = cfg_en;
        if (start) begin
            ctl_d.active    = 1'b1;
            ctl_d.trig      = 1'b0;
            ctl_d.buf_sel   = 1'b0;
            ctl_d.pfc       = cfg_pfc;
            ctl_d.wrap_mode = cfg_circ || cfg_dbuf;
            ctl_d.dbuf      = cfg_dbuf;
            ctl_d.dir       = dir_e'(cfg_dir);
            ctl_d.rem       = cfg_count;
            ctl_d.len       = cfg_count;
        end else if (ctl_q.active) begin
            if (beat && !ctl_q.pfc) begin
                ctl_d.rem = wrap ? ctl_q.len : rem_dec;
            end
            if (wrap && ctl_q.dbuf) begin
                ctl_d.buf_sel = !ctl_q.buf_sel;
            end
            if (ctl_q.dir == DIR_M2M && sw_trig) begin
                ctl_d.trig = 1'b1;
            end
            if (stop) begin
                ctl_d.active = 1'b0;
                ctl_d.trig   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    dma_seq_addr #(.AW(AW)) u_per_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start || wrap),
        .load_val  (cfg_paddr),
        .step_en   (beat),
        .inc_en    (cfg_pinc),
        .size_code (cfg_psize),
        .addr      (per_addr)
    );

    dma_seq_addr #(.AW(AW)) u_mem_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start || wrap),
        .load_val  (mem_reload),
        .step_en   (beat),
        .inc_en    (cfg_minc),
        .size_code (cfg_msize),
        .addr      (mem_addr)
    );

    dma_seq_flags #(.NF(NUM_FLAGS)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (ev),
        .clr   (flag_clr),
        .ie    (flag_ie),
        .flags (flags),
        .irq   (irq)
    );

    assign src_addr  = (ctl_q.dir == DIR_M2P) ? mem_addr : per_addr;
    assign dst_addr  = (ctl_q.dir == DIR_M2P) ? per_addr : mem_addr;
    assign remaining = ctl_q.rem;
    assign active    = ctl_q.active;
    assign buf_sel   = ctl_q.buf_sel;

    AST_REM_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.active && !ctl_q.pfc) |-> (ctl_q.rem != '0)); // R4
    AST_DONE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !ctl_q.wrap_mode) |=> !active); // R4
    AST_BUF_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (last && ctl_q.dbuf) |=> (buf_sel != $past(buf_sel))); // R6
    AST_PFC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.active && ctl_q.pfc) |=> $stable(remaining)); // R8
    AST_TE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (active && err_xfer) |=> !active); // R10
    AST_NO_ITEM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> $stable(remaining) || active); // R2

endmodule

// File: tb/test_dma_stream_seq.sv
`timescale 1ns/1ps
module test_dma_stream_seq;

    localparam logic [31:0] PA = 32'h4000_0000;
    localparam logic [31:0] M0 = 32'h2000_0100;
    localparam logic [31:0] M1 = 32'h2000_8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 0, cfg_pfc = 0, cfg_circ = 0, cfg_dbuf = 0, cfg_pinc = 1, cfg_minc = 1;
    logic [1:0]  cfg_dir = 0, cfg_psize = 2, cfg_msize = 2;
    logic [15:0] cfg_count = 0;
    logic [31:0] cfg_paddr = PA, cfg_m0addr = M0, cfg_m1addr = M1;
    logic [4:0]  flag_ie = 0, flag_clr = 0;
    logic        sw_trig = 0, item_req = 0, xfer_ack = 0, periph_end = 0;
    logic        err_xfer = 0, err_fifo = 0, err_direct = 0;
    logic        xfer_valid, active, buf_sel, irq;
    logic [31:0] src_addr, dst_addr;
    logic [15:0] remaining;
    logic [4:0]  flags;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dma_stream_seq i_dma_stream_seq (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_dir(cfg_dir), .cfg_pfc(cfg_pfc),
        .cfg_circ(cfg_circ), .cfg_dbuf(cfg_dbuf), .cfg_pinc(cfg_pinc), .cfg_minc(cfg_minc),
        .cfg_psize(cfg_psize), .cfg_msize(cfg_msize), .cfg_count(cfg_count),
        .cfg_paddr(cfg_paddr), .cfg_m0addr(cfg_m0addr), .cfg_m1addr(cfg_m1addr),
        .flag_ie(flag_ie), .flag_clr(flag_clr), .sw_trig(sw_trig), .item_req(item_req),
        .xfer_ack(xfer_ack), .periph_end(periph_end), .err_xfer(err_xfer),
        .err_fifo(err_fifo), .err_direct(err_direct), .xfer_valid(xfer_valid),
        .src_addr(src_addr), .dst_addr(dst_addr), .remaining(remaining), .active(active),
        .buf_sel(buf_sel), .flags(flags), .irq(irq)
    );

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // idle the stream, clear flags, apply configuration, raise enable; returns at the negedge after start
    task automatic open_xfer(input int dir, input int n, input bit pfc, input bit circ, input bit dbuf);
        @(negedge clk);
        cfg_en = 0; item_req = 0; xfer_ack = 0; flag_clr = '1;
        @(negedge clk);
        flag_clr = '0; cfg_dir = 2'(dir); cfg_count = 16'(n);
        cfg_pfc = pfc; cfg_circ = circ; cfg_dbuf = dbuf;
        @(negedge clk);
        cfg_en = 1;
        @(negedge clk);
    endtask

    task automatic sweep_run(input int dir, input int ps, input int ms, input bit pi, input bit mi,
                             input int mode, input int n);
        logic [31:0] pa, ma;
        int rem, beats;
        bit bsel, ht, tc;
        cfg_psize = 2'(ps); cfg_msize = 2'(ms); cfg_pinc = pi; cfg_minc = mi;
        open_xfer(dir, n, 0, mode == 1, mode == 2);
        pa = PA; ma = M0; rem = n; bsel = 0; ht = 0; tc = 0;
        chk("R1", "start active", active, 1);
        chk("R1", "start count", remaining, n);
        chk("R1", "start buffer", buf_sel, 0);
        chk("R1", "start flags", flags, 0);
        item_req = 1; xfer_ack = 1;
        if (dir == 2) begin
            sw_trig = 1;
            @(negedge clk);
            sw_trig = 0;
        end
        beats = (mode == 0) ? n : 2 * n + 1;
        for (int k = 0; k < beats; k++) begin
            chk("R3", "src", src_addr, (dir == 1) ? ma : pa);
            chk("R3", "dst", dst_addr, (dir == 1) ? pa : ma);
            @(negedge clk);
            pa = pa + (pi ? (32'd1 << ps) : 32'd0);
            ma = ma + (mi ? (32'd1 << ms) : 32'd0);
            rem--;
            if (rem == n / 2) ht = 1;
            if (rem == 0) begin
                tc = 1;
                if (mode != 0) begin
                    rem = n; pa = PA;
                    if (mode == 2) bsel = !bsel;
                    ma = (mode == 2 && bsel) ? M1 : M0;
                end
            end
            chk((mode == 0) ? "R4" : "R5", "remaining", remaining, rem);
            chk("R4", "active", active, (mode != 0) || (rem != 0));
            chk("R6", "buf_sel", buf_sel, bsel);
            chk("R7", "half flag", flags[0], ht);
            chk("R4", "complete flag", flags[1], tc);
        end
        chk("R5", "src after run", src_addr, (dir == 1) ? ma : pa);
        chk("R6", "dst after run", dst_addr, (dir == 1) ? pa : ma);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R2 watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "reset active", active, 0);
        chk("R11", "reset flags", flags, 0);
        chk("R12", "reset irq", irq, 0);
        chk("R2", "reset valid", xfer_valid, 0);

        // R1: zero count under item-count control does not start
        open_xfer(0, 0, 0, 0, 0);
        chk("R1", "zero count ignored", active, 0);

        // R2: request without acknowledge stalls
        cfg_psize = 2; cfg_msize = 2; cfg_pinc = 1; cfg_minc = 1;
        open_xfer(0, 3, 0, 0, 0);
        item_req = 1; xfer_ack = 0;
        #1 chk("R2", "valid with request", xfer_valid, 1);
        repeat (2) @(negedge clk);
        chk("R2", "no ack holds count", remaining, 3);
        item_req = 0; xfer_ack = 1;
        #1 chk("R2", "valid without request", xfer_valid, 0);
        @(negedge clk);
        chk("R2", "no request holds count", remaining, 3);

        // R9: memory-to-memory waits for the trigger
        open_xfer(2, 5, 0, 0, 0);
        item_req = 1; xfer_ack = 1;
        repeat (2) @(negedge clk);
        chk("R9", "request ignored", remaining, 5);
        sw_trig = 1;
        @(negedge clk);
        sw_trig = 0;
        chk("R9", "no item on trigger edge", remaining, 5);
        repeat (3) @(negedge clk);
        chk("R9", "items after trigger", remaining, 2);

        // R8: peripheral flow control
        open_xfer(0, 0, 1, 0, 0);
        chk("R8", "pfc starts with zero count", active, 1);
        item_req = 1; xfer_ack = 1;
        repeat (4) @(negedge clk);
        chk("R8", "count held", remaining, 0);
        chk("R8", "source advanced", src_addr, PA + 32'd16);
        item_req = 0; periph_end = 1;
        @(negedge clk);
        periph_end = 0;
        chk("R8", "end stops", active, 0);
        chk("R8", "end flags", flags, 5'b00010);

        // R13: enable drop stops without completion
        open_xfer(0, 5, 0, 0, 0);
        item_req = 1; xfer_ack = 1;
        repeat (2) @(negedge clk);
        cfg_en = 0; item_req = 0;
        @(negedge clk);
        chk("R13", "stopped", active, 0);
        chk("R13", "count held", remaining, 3);
        chk("R13", "no complete", flags[1], 0);

        // R10 / R11 / R12: errors, clearing, interrupt masking
        open_xfer(0, 4, 0, 0, 0);
        err_fifo = 1;
        @(negedge clk);
        err_fifo = 0;
        chk("R10", "fifo flag", flags, 5'b01000);
        chk("R10", "fifo keeps running", active, 1);
        err_direct = 1;
        @(negedge clk);
        err_direct = 0;
        chk("R10", "direct flag", flags, 5'b11000);
        chk("R10", "direct keeps running", active, 1);
        err_fifo = 1; flag_clr = 5'b01000;
        @(negedge clk);
        err_fifo = 0; flag_clr = 0;
        chk("R11", "set wins over clear", flags, 5'b11000);
        flag_clr = 5'b10000;
        @(negedge clk);
        flag_clr = 0;
        chk("R11", "write one clears", flags, 5'b01000);
        @(negedge clk);
        chk("R11", "sticky", flags, 5'b01000);
        err_xfer = 1;
        @(negedge clk);
        err_xfer = 0;
        chk("R10", "xfer error flag", flags, 5'b01100);
        chk("R10", "xfer error stops", active, 0);
        flag_ie = 5'b00000;
        #1 chk("R12", "all masked", irq, 0);
        flag_ie = 5'b00100;
        #1 chk("R12", "error enabled", irq, 1);
        flag_ie = 5'b10011;
        #1 chk("R12", "other bits enabled", irq, 0);
        flag_ie = 5'b11111;
        #1 chk("R12", "all enabled", irq, 1);
        flag_ie = 0;

        // near-exhaustive sweep
        for (int dir = 0; dir < 3; dir++)
            for (int ps = 0; ps < 3; ps++)
                for (int ms = 0; ms < 3; ms++)
                    for (int inc = 0; inc < 4; inc++)
                        for (int mode = 0; mode < 3; mode++)
                            for (int n = 1; n <= 5; n++)
                                sweep_run(dir, ps, ms, inc[0], inc[1], mode, n);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule